// File: doc/BRIEF.md
# Fault Status Capture Unit

This block sits at the end of a memory management pipeline. In a single cycle it takes up to twelve abort flags that can be raised together and picks one of them by a fixed ranking. It encodes that fault as a five-bit code, together with a domain number and a bus-error type, and writes the result into a data-side or an instruction-side status register. Depending on the kind of access, it also captures the faulting data address and the address of the instruction that caused the abort.

The access kind comes in on `op_kind`. The kinds are an ordinary data access, an instruction fetch, a data-cache maintenance operation by address and an instruction-cache maintenance operation by address. The instruction-cache maintenance case is taken as a data abort. When it hits a translation fault, the data-side register gets a dedicated maintenance code and the instruction-side register gets the real cause. A one-cycle strobe marks every cycle in which the registers are loaded.

Top module: `fsc_capture`

## Requirements
- R1: `flt_vec` bit positions set the ranking, with bit 0 the highest: 0 alignment, 1 TLB miss, 2 external abort on first-level walk, 3 external abort on second-level walk, 4 translation, 5 access-bit, 6 domain, 7 permission, 8 precise external, 9 imprecise external, 10 parity, 11 debug event. The lowest-numbered set bit is the one reported.
- R2: The codes are as follows. Alignment 00001. TLB miss 00000. Walk external first-level 01100 and second-level 01110. Translation: section 00101, page 00111. Access-bit: section 00011, page 00110. Domain: section 01001, page 01011. Permission: section 01101, page 01111. Precise 01000. Imprecise 10110. Parity 11000. Debug 00010. Instruction-cache maintenance 00100. `pg_kind`=1 selects the page form. No other code is ever written.
- R3: Status word layout: bit 12 is the slave-error flag, bit 10 is code bit 4, bits 7:4 are the domain and bits 3:0 are code bits 3:0. Every other bit is zero.
- R4: On the data side the domain field takes `dom_in` only for these faults: second-level walk external, page translation, access-bit, domain, permission, precise external and debug. For all other faults it is zero. It is always zero in the instruction-side register.
- R5: Bit 12 equals `slv_err` for the four external-abort kinds (sources 2, 3, 8, 9) and is zero for every other kind.
- R6: `op_kind`=0 (data access) loads the data-side status and the fault address. The instruction-side status and the instruction address hold.
- R7: `op_kind`=2 (data-cache maintenance) loads the data-side status, the fault address and the instruction address. The instruction-side status holds.
- R8: `op_kind`=1 (instruction fetch) loads the instruction-side status and the instruction address. The data-side status and the fault address hold.
- R9: `op_kind`=3 with the translation flag set and neither alignment nor TLB miss set loads four things. The data-side status gets code 00100 with a zero domain and bit 12 clear. The instruction-side status gets the word of the ranked winner. Both address registers are loaded. In any other case, `op_kind`=3 acts as `op_kind`=2.
- R10: `abort_stb` is high in the cycle after a cycle in which any flag is set. Registers change only on those edges. A cycle with no flag changes nothing.
- R11: After reset all four registers read zero and `abort_stb` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flt_vec | input | 12 | Abort flags, bit order as in R1 |
| pg_kind | input | 1 | 1 = page, 0 = section, for translation/access/domain/permission |
| dom_in | input | DOM_W | Domain number of the access |
| slv_err | input | 1 | 1 = slave error, 0 = decode error, for external aborts |
| data_addr | input | AW | Faulting data address |
| instr_addr | input | AW | Address of the faulting instruction |
| op_kind | input | 2 | 0 data, 1 fetch, 2 D-cache maintenance, 3 I-cache maintenance |
| dfsr_q | output | FSR_W | Data-side fault status |
| ifsr_q | output | FSR_W | Instruction-side fault status |
| far_q | output | AW | Fault address |
| ifar_q | output | AW | Instruction fault address |
| abort_stb | output | 1 | Registers were loaded on the last edge |

## Verification
The bench targets the following corner cases:

- **Ranking:** every source is driven together with all lower-ranked ones. A ranking that is off by one position would report a lower-ranked neighbour's code.
- **Section/page pairs:** each pair is driven with both `pg_kind` values and with domain and slave error both on and off. Swapped codes, or a domain leaking into the section translation or first-level walk cases, show up directly in the status word.
- **Instruction-cache maintenance:** this case is driven alone, with alignment or TLB miss present, and together with a higher-ranked walk abort. A design that wrote 00100 into both registers, or took the maintenance path when alignment was present, would be caught.
- **Fetch aborts and idle cycles:** the bench checks that the fault address and the data-side status do not move on fetch aborts and that nothing moves in idle cycles.

// File: rtl/fsc_pkg.sv
package fsc_pkg;

   localparam int NSRC  = 12;
   localparam int IDX_W = 4;

   typedef enum logic [1:0] {
      OP_DATA = 2'd0,
      OP_INSN = 2'd1,
      OP_DCM  = 2'd2,
      OP_ICM  = 2'd3
   } op_e;

   // source index = ranking position, 0 is strongest
   localparam int S_ALIGN = 0;
   localparam int S_TLB   = 1;
   localparam int S_XL1   = 2;
   localparam int S_XL2   = 3;
   localparam int S_TRANS = 4;
   localparam int S_ACC   = 5;
   localparam int S_DOM   = 6;
   localparam int S_PERM  = 7;
   localparam int S_PREC  = 8;
   localparam int S_IMPR  = 9;
   localparam int S_PAR   = 10;
   localparam int S_DBG   = 11;

   localparam logic [4:0] CODE_ICM = 5'b00100;

   function automatic logic [4:0] fsc_code(input logic [IDX_W-1:0] idx, input logic page);
      case (idx)
         4'd0:    return 5'b00001;
         4'd1:    return 5'b00000;
         4'd2:    return 5'b01100;
         4'd3:    return 5'b01110;
         4'd4:    return page ? 5'b00111 : 5'b00101;
         4'd5:    return page ? 5'b00110 : 5'b00011;
         4'd6:    return page ? 5'b01011 : 5'b01001;
         4'd7:    return page ? 5'b01111 : 5'b01101;
         4'd8:    return 5'b01000;
         4'd9:    return 5'b10110;
         4'd10:   return 5'b11000;
         4'd11:   return 5'b00010;
         default: return 5'b00000;
      endcase
   endfunction

   function automatic logic dom_valid(input logic [IDX_W-1:0] idx, input logic page);
      case (idx)
         4'd3, 4'd5, 4'd6, 4'd7, 4'd8, 4'd11: return 1'b1;
         4'd4:                                return page;
         default:                             return 1'b0;
      endcase
   endfunction

   function automatic logic is_ext(input logic [IDX_W-1:0] idx);
      return (idx == 4'd2) || (idx == 4'd3) || (idx == 4'd8) || (idx == 4'd9);
   endfunction

   function automatic logic code_legal(input logic [4:0] c);
      case (c)
         5'b00000, 5'b00001, 5'b00010, 5'b00011, 5'b00100, 5'b00101,
         5'b00110, 5'b00111, 5'b01000, 5'b01001, 5'b01011, 5'b01100,
         5'b01101, 5'b01110, 5'b01111, 5'b10110, 5'b11000: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/fsc_prio.sv
module fsc_prio #(
   parameter int N  = 12,
   localparam int IW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic [N-1:0]  grant,
   output logic [IW-1:0] idx,
   output logic          any
);

   logic [N:0] seen;
   assign seen[0] = 1'b0;

   generate
      for (genvar g = 0; g < N; g++) begin : g_rank
         assign seen[g+1] = seen[g] | req[g];
         assign grant[g]  = req[g] & ~seen[g];
      end
   endgenerate

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (grant[i]) idx = IW'(i);
      end
   end

   // R1: at most one source wins, and one wins whenever any is asking
   always_comb begin
      p_one_winner_r1: assert ($onehot0(grant) && ((|grant) == (|req)));
   end

endmodule

// File: rtl/fsc_encode.sv
module fsc_encode
   import fsc_pkg::*;
#(
   parameter int FSR_W = 32,
   parameter int DOM_W = 4
) (
   input  logic [IDX_W-1:0] idx,
   input  logic             page,
   input  logic [DOM_W-1:0] dom,
   input  logic             slv,
   input  logic             dom_en,
   output logic [FSR_W-1:0] word
);

   logic [4:0] code;
   assign code = fsc_code(idx, page);

   always_comb begin
      word       = '0;
      word[12]   = is_ext(idx) & slv;
      word[10]   = code[4];
      word[7:4]  = (dom_en && dom_valid(idx, page)) ? dom : '0;
      word[3:0]  = code[3:0];
   end

   // R2: reserved codes are never formed
   always_comb begin
      p_no_reserved_r2: assert (code_legal({word[10], word[3:0]}));
   end

endmodule

// File: rtl/fsc_capture.sv
module fsc_capture
   import fsc_pkg::*;
#(
   parameter int AW     = 32,
   parameter int FSR_W  = 32,
   parameter int DOM_W  = 4,
   parameter bit ICM_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [11:0]      flt_vec,
   input  logic             pg_kind,
   input  logic [DOM_W-1:0] dom_in,
   input  logic             slv_err,
   input  logic [AW-1:0]    data_addr,
   input  logic [AW-1:0]    instr_addr,
   input  logic [1:0]       op_kind,
   output logic [FSR_W-1:0] dfsr_q,
   output logic [FSR_W-1:0] ifsr_q,
   output logic [AW-1:0]    far_q,
   output logic [AW-1:0]    ifar_q,
   output logic             abort_stb
);

   localparam logic [FSR_W-1:0] USED_MASK = FSR_W'(32'h0000_14FF);

   generate
      if (FSR_W < 13) begin : g_bad_fsr_w
         $error("fsc_capture: FSR_W must be at least 13");
      end
      if (DOM_W != 4) begin : g_bad_dom_w
         $error("fsc_capture: domain field occupies bits 7:4, DOM_W must be 4");
      end
      if (AW < 1) begin : g_bad_aw
         $error("fsc_capture: AW must be positive");
      end
   endgenerate

   logic [NSRC-1:0]  grant;
   logic [IDX_W-1:0] win;
   logic             any;
   logic [FSR_W-1:0] d_word, i_word, icm_word;
   logic             icm_hit;
   op_e              op;

   assign op = op_e'(op_kind);

   fsc_prio #(.N(NSRC)) u_prio (
      .req   (flt_vec),
      .grant (grant),
      .idx   (win),
      .any   (any)
   );

   fsc_encode #(.FSR_W(FSR_W), .DOM_W(DOM_W)) u_enc_d (
      .idx (win), .page (pg_kind), .dom (dom_in), .slv (slv_err),
      .dom_en (1'b1), .word (d_word)
   );

   fsc_encode #(.FSR_W(FSR_W), .DOM_W(DOM_W)) u_enc_i (
      .idx (win), .page (pg_kind), .dom (dom_in), .slv (slv_err),
      .dom_en (1'b0), .word (i_word)
   );

   always_comb begin
      icm_word      = '0;
      icm_word[10]  = CODE_ICM[4];
      icm_word[3:0] = CODE_ICM[3:0];
   end

   generate
      if (ICM_EN) begin : g_icm
         assign icm_hit = (op == OP_ICM) && flt_vec[S_TRANS]
                          && !flt_vec[S_ALIGN] && !flt_vec[S_TLB];
      end else begin : g_no_icm
         assign icm_hit = 1'b0;
      end
   endgenerate

   logic ld_d, ld_i, ld_f, ld_ia;

   always_comb begin
      ld_d = 1'b0; ld_i = 1'b0; ld_f = 1'b0; ld_ia = 1'b0;
      if (any) begin
         unique case (op)
            OP_DATA: begin ld_d = 1'b1; ld_f = 1'b1; end
            OP_INSN: begin ld_i = 1'b1; ld_ia = 1'b1; end
            OP_DCM, OP_ICM: begin
               ld_d = 1'b1; ld_f = 1'b1; ld_ia = 1'b1;
               ld_i = icm_hit;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         dfsr_q    <= '0;
         ifsr_q    <= '0;
         far_q     <= '0;
         ifar_q    <= '0;
         abort_stb <= 1'b0;
      end else begin
         abort_stb <= any;
         if (ld_d)  dfsr_q <= icm_hit ? icm_word : d_word;
         if (ld_i)  ifsr_q <= i_word;
         if (ld_f)  far_q  <= data_addr;
         if (ld_ia) ifar_q <= instr_addr;
      end
   end

   // R10: idle cycle leaves everything alone
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(|flt_vec) |=> (!abort_stb && $stable(dfsr_q) && $stable(ifsr_q)
                       && $stable(far_q) && $stable(ifar_q)));

   // R10: any flag gives a strobe on the next cycle
   p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (|flt_vec) |=> abort_stb);

   // R8: fetch aborts leave the data-side state alone
   p_fetch_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((|flt_vec) && op_kind == 2'd1) |=> ($stable(far_q) && $stable(dfsr_q)));

   // R9: maintenance code on the data side, no domain, no bus flag
   p_icm_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
      icm_hit |=> (dfsr_q[3:0] == 4'b0100 && !dfsr_q[10]
                   && dfsr_q[7:4] == 4'd0 && !dfsr_q[12]));

   // R3: unused status bits stay zero
   p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ((dfsr_q & ~USED_MASK) == '0) && ((ifsr_q & ~USED_MASK) == '0));

   // R2: registered codes are never reserved ones
   p_legal_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
      abort_stb |-> (code_legal({dfsr_q[10], dfsr_q[3:0]})
                     && code_legal({ifsr_q[10], ifsr_q[3:0]})));

endmodule

// File: tb/sim_fsc_capture.sv
`timescale 1ns/1ps
module sim_fsc_capture;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [11:0] flt_vec = '0;
   logic        pg_kind = 1'b0;
   logic [3:0]  dom_in = '0;
   logic        slv_err = 1'b0;
   logic [31:0] data_addr = '0, instr_addr = '0;
   logic [1:0]  op_kind = '0;
   logic [31:0] dfsr_q, ifsr_q, far_q, ifar_q;
   logic        abort_stb;

   int n_checks = 0;
   int n_errors = 0;

   logic [31:0] m_dfsr = '0, m_ifsr = '0, m_far = '0, m_ifar = '0;
   logic        m_stb = 1'b0;

   always #2.5 clk = ~clk;

   fsc_capture u0 (
      .clk (clk), .rst_n (rst_n), .flt_vec (flt_vec), .pg_kind (pg_kind),
      .dom_in (dom_in), .slv_err (slv_err), .data_addr (data_addr),
      .instr_addr (instr_addr), .op_kind (op_kind), .dfsr_q (dfsr_q),
      .ifsr_q (ifsr_q), .far_q (far_q), .ifar_q (ifar_q), .abort_stb (abort_stb)
   );

   function automatic logic [4:0] r_code(int i, bit pg);
      case (i)
         0: return 5'b00001;  1: return 5'b00000;
         2: return 5'b01100;  3: return 5'b01110;
         4: return pg ? 5'b00111 : 5'b00101;
         5: return pg ? 5'b00110 : 5'b00011;
         6: return pg ? 5'b01011 : 5'b01001;
         7: return pg ? 5'b01111 : 5'b01101;
         8: return 5'b01000;  9: return 5'b10110;
         10: return 5'b11000; default: return 5'b00010;
      endcase
   endfunction

   function automatic bit r_domv(int i, bit pg);
      return (i == 3) || (i == 4 && pg) || (i >= 5 && i <= 8) || (i == 11);
   endfunction

   function automatic bit r_ext(int i);
      return (i == 2) || (i == 3) || (i == 8) || (i == 9);
   endfunction

   function automatic logic [31:0] r_pack(logic [4:0] c, logic [3:0] d, bit b12);
      logic [31:0] w;
      w = '0; w[12] = b12; w[10] = c[4]; w[7:4] = d; w[3:0] = c[3:0];
      return w;
   endfunction

   function automatic int r_win(logic [11:0] f);
      for (int i = 0; i < 12; i++) if (f[i]) return i;
      return -1;
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(string tag, logic [11:0] f, bit pg, logic [3:0] d, bit s,
                       logic [31:0] da, logic [31:0] ia, logic [1:0] op);
      int w;
      logic [31:0] dw, iw;
      bit icm;
      flt_vec = f; pg_kind = pg; dom_in = d; slv_err = s;
      data_addr = da; instr_addr = ia; op_kind = op;
      w = r_win(f);
      m_stb = (f != 0);
      if (w >= 0) begin
         dw = r_pack(r_code(w, pg), r_domv(w, pg) ? d : 4'd0, r_ext(w) ? s : 1'b0);
         iw = r_pack(r_code(w, pg), 4'd0, r_ext(w) ? s : 1'b0);
         icm = (op == 2'd3) && f[4] && !f[0] && !f[1];
         case (op)
            2'd0: begin m_dfsr = dw; m_far = da; end
            2'd1: begin m_ifsr = iw; m_ifar = ia; end
            default: begin
               m_far = da; m_ifar = ia;
               if (icm) begin m_dfsr = r_pack(5'b00100, 4'd0, 1'b0); m_ifsr = iw; end
               else m_dfsr = dw;
            end
         endcase
      end
      @(posedge clk);
      @(negedge clk);
      chk(tag, "dfsr", dfsr_q, m_dfsr);
      chk(tag, "ifsr", ifsr_q, m_ifsr);
      chk(tag, "far", far_q, m_far);
      chk(tag, "ifar", ifar_q, m_ifar);
      chk(tag, "stb", {31'd0, abort_stb}, {31'd0, m_stb});
   endtask

   initial begin
      #(200000 * 5);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      process::self().srandom(32'd1776);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R11: reset state
      chk("R11", "dfsr", dfsr_q, 32'd0);
      chk("R11", "ifsr", ifsr_q, 32'd0);
      chk("R11", "far", far_q, 32'd0);
      chk("R11", "ifar", ifar_q, 32'd0);
      chk("R11", "stb", {31'd0, abort_stb}, 32'd0);

      // R2 / R4 / R5 / R3: each source, both kinds, data side and fetch side
      for (int i = 0; i < 12; i++) begin
         for (int pg = 0; pg < 2; pg++) begin
            step("R2", 12'(1 << i), pg[0], 4'hA, 1'b1, 32'h1000_0000 + i, 32'h2000_0000 + i, 2'd0);
            step("R4", 12'(1 << i), pg[0], 4'h5, 1'b0, 32'h3000_0000 + i, 32'h4000_0000 + i, 2'd0);
            step("R5", 12'(1 << i), pg[0], 4'hF, 1'b1, 32'h5000_0000 + i, 32'h6000_0000 + i, 2'd1);
         end
      end
      step("R3", 12'h008, 1'b1, 4'hF, 1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd0);

      // R1: each source against all weaker ones
      for (int i = 0; i < 12; i++)
         step("R1", 12'hFFF << i, 1'b1, 4'h3, 1'b1, 32'h7000_0000 + i, 32'h7100_0000 + i, 2'd0);

      // R6 / R7 / R8 directed
      step("R6", 12'h040, 1'b0, 4'h2, 1'b0, 32'hA0A0_0001, 32'hB0B0_0001, 2'd0);
      step("R7", 12'h080, 1'b1, 4'h4, 1'b0, 32'hA0A0_0002, 32'hB0B0_0002, 2'd2);
      step("R8", 12'h010, 1'b1, 4'h6, 1'b0, 32'hA0A0_0003, 32'hB0B0_0003, 2'd1);

      // R9: maintenance alone, masked by alignment / TLB miss, behind walk abort
      step("R9", 12'h010, 1'b1, 4'h9, 1'b1, 32'hC000_0001, 32'hD000_0001, 2'd3);
      step("R9", 12'h011, 1'b1, 4'h9, 1'b1, 32'hC000_0002, 32'hD000_0002, 2'd3);
      step("R9", 12'h012, 1'b0, 4'h9, 1'b1, 32'hC000_0003, 32'hD000_0003, 2'd3);
      step("R9", 12'h018, 1'b0, 4'h9, 1'b1, 32'hC000_0004, 32'hD000_0004, 2'd3);
      step("R9", 12'h020, 1'b1, 4'h9, 1'b1, 32'hC000_0005, 32'hD000_0005, 2'd3);
      step("R9", 12'h014, 1'b0, 4'h9, 1'b0, 32'hC000_0006, 32'hD000_0006, 2'd3);

      // R10: idle cycles hold
      for (int k = 0; k < 4; k++)
         step("R10", 12'h000, k[0], 4'hC, 1'b1, 32'hEEEE_0000 + k, 32'hDDDD_0000 + k, 2'(k));

      // mixed random
      for (int n = 0; n < 800; n++) begin
         logic [11:0] f;
         logic [1:0]  op;
         string tg;
         f  = ($urandom_range(0, 3) == 0) ? 12'd0 : 12'($urandom);
         if ($urandom_range(0, 1) == 1) f = f & 12'hFF0;
         op = 2'($urandom_range(0, 3));
         if (f == 0) tg = "R10";
         else case (op)
            2'd0: tg = "R6"; 2'd1: tg = "R8"; 2'd2: tg = "R7"; default: tg = "R9";
         endcase
         step(tg, f, 1'($urandom), 4'($urandom), 1'($urandom), $urandom, $urandom, op);
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule